// File: doc/BRIEF.md
# Dual-Channel Compare Timer

This block is a 16-bit up-counter with two output-compare channels, called A and B. The counter advances one step every eighth clock cycle while its run input is high. Each channel holds its own compare value. On a count step where the counter equals that value, the channel toggles, clears or sets its output pin, as its 2-bit action field selects. Each channel also raises an override flag. The flag tells the surrounding port logic that the compare output should replace the pin's ordinary function. It is raised only when the channel's action field is nonzero and the channel's direction input is high.

Software programs the block through a single write port. Address 0 is the control byte, address 1 is the compare value of channel A, address 2 is the compare value of channel B, address 3 is the counter and address 4 is the flag-clear register. The wave-select field picks the counting mode:
- Free-running mode wraps at all-ones.
- Clear-on-match mode restarts from zero after reaching channel A's compare value.
- Buffered mode also wraps at all-ones. In this mode, writes to the compare values are parked in a buffer and become active only at the top of the count.

Top module: `cmp_timer`

## Requirements
- R1: After synchronous active-low reset, the counter is 0, both pins are 0, both override flags are 0 and the overflow flag is 0. All control bits are also 0: free-running mode, both actions off.
- R2: While `cnt_run` is high, the counter advances by one every 8 clock cycles. The first step comes 8 cycles after `cnt_run` rises. While `cnt_run` is low, the counter holds and the divide-by-8 phase restarts.
- R3: A count step taken while the counter is 0xFFFF moves it to 0 and sets `ovf_flag`. Writing data bit 0 = 1 to address 4 clears the flag. A set and a clear in the same cycle leave the flag set.
- R4: With control bits 1:0 = 01 (clear-on-match), a count step taken while the counter equals channel A's active compare value moves the counter to 0.
- R5: A channel matches on a count step taken while the counter equals its active compare value. On the edge ending that step, action 01 inverts the pin, action 10 drives it to 0 and action 11 drives it to 1. Channel A's action is in control bits 7:6 and channel B's action is in control bits 5:4.
- R6: With action 00, a channel's pin keeps its value through matches and its override flag stays 0, whatever its direction input.
- R7: A channel's override flag is 1 exactly when its action field is nonzero and its direction input (`dir_a` or `dir_b`) is 1.
- R8: After a write to the counter, the next count step produces no match on either channel, even when the written value equals a compare value.
- R9: With control bits 1:0 = 10 or 11 (buffered), a compare write takes effect only at a count step taken while the counter is 0xFFFF. Before that step, matches use the previous value. In modes 00 and 01 the write takes effect on the next edge.
- R10: A counter write in the same cycle as a count step wins. The counter takes the written value and does not advance. Control bits 3:2 always stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 control, 1 compare A, 2 compare B, 3 counter, 4 flag clear |
| wr_data | input | 16 | Write data; the control byte uses bits 7:0 |
| cnt_run | input | 1 | Enables the divide-by-8 count steps |
| dir_a | input | 1 | Direction bit for channel A's pin |
| dir_b | input | 1 | Direction bit for channel B's pin |
| count | output | 16 | Current counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| pin_a | output | 1 | Channel A compare output value |
| pin_b | output | 1 | Channel B compare output value |
| ovr_a | output | 1 | Channel A overrides the ordinary pin function |
| ovr_b | output | 1 | Channel B overrides the ordinary pin function |

## Verification
A register write is visible at the ports one edge after the strobe. A count step, and any pin change or flag set it causes, appears on the edge that ends the eighth cycle of the divide-by-8 phase. The override flags follow the direction inputs with no register delay. The bench drives inputs just after each falling edge and updates its behavioural model at the rising edge from the same inputs. It compares every output at the following falling edge, so each comparison lands after all the registers in the path have settled. Each comparison is tagged with the requirement that the current stimulus phase targets.

// File: rtl/cmp_timer_pkg.sv
// Package: shared encodings for the dual-channel compare timer.
// Assumes a 3-bit register address space and an 8-bit control byte.
package cmp_timer_pkg;

    typedef enum logic [1:0] {
        ACT_OFF    = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        WAVE_FREE  = 2'b00,
        WAVE_CTC   = 2'b01,
        WAVE_BUF0  = 2'b10,
        WAVE_BUF1  = 2'b11
    } wave_e;

    localparam logic [2:0] ADDR_CTRL = 3'd0;
    localparam logic [2:0] ADDR_CMPA = 3'd1;
    localparam logic [2:0] ADDR_CMPB = 3'd2;
    localparam logic [2:0] ADDR_CNT  = 3'd3;
    localparam logic [2:0] ADDR_FLAG = 3'd4;

endpackage

// File: rtl/cmp_prescaler.sv
// Module: divide-by-DIV step generator.
// Produces a one-cycle tick every DIV cycles while run is high.
// Assumes DIV >= 2. The phase restarts whenever run is low.
module cmp_prescaler #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    // Phase counter: counts 0..DIV-1 while running, otherwise parks at 0.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)    phase_q <= '0;
        else if (phase_q == LAST) phase_q <= '0;
        else                   phase_q <= phase_q + 1'b1;
    end

    assign tick = run && (phase_q == LAST);

    // Two ticks can never come back to back when DIV >= 2.
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/cmp_counter.sv
// Module: the counter, overflow flag and post-write match block.
// Handles the free-running, clear-on-match and buffered counting modes.
// Assumes tick is a single-cycle step enable. A counter write overrides a step.
module cmp_counter #(
    parameter int W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick,
    input  logic                      wr_cnt,
    input  logic [W-1:0]              wr_val,
    input  logic                      clr_ovf,
    input  cmp_timer_pkg::wave_e      wave,
    input  logic [W-1:0]              ctc_top,
    output logic [W-1:0]              cnt,
    output logic                      ovf,
    output logic                      blk,
    output logic                      step,
    output logic                      top_step
);
    import cmp_timer_pkg::*;

    localparam logic [W-1:0] MAXV = '1;

    logic at_top;

    assign step     = tick && !wr_cnt;
    assign at_top   = (wave == WAVE_CTC) ? (cnt == ctc_top) : (cnt == MAXV);
    assign top_step = step && at_top;

    // Counter: a write wins, otherwise step up or restart from zero at TOP.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (wr_cnt)   cnt <= wr_val;
        else if (step)     cnt <= at_top ? '0 : cnt + 1'b1;
    end

    // Overflow flag: set on a step from all-ones; a set beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                      ovf <= 1'b0;
        else if (step && cnt == MAXV)    ovf <= 1'b1;
        else if (clr_ovf)                ovf <= 1'b0;
    end

    // Match block: armed by a counter write, released by the next tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      blk <= 1'b0;
        else if (wr_cnt) blk <= 1'b1;
        else if (tick)   blk <= 1'b0;
    end

    assert_wrap_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt == MAXV) |=> ovf);

    assert_ctc_return_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && wave == WAVE_CTC && cnt == ctc_top) |=> (cnt == '0));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_cnt) |=> $stable(cnt));

    assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cnt == $past(wr_val)));

endmodule

// File: rtl/cmp_channel.sv
// Module: one output-compare channel.
// Holds the buffered and active compare values, detects a match on a count
// step and applies the selected pin action. Assumes step, top_step and blk
// come from cmp_counter in the same cycle as cnt.
module cmp_channel #(
    parameter int W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_cmp,
    input  logic [W-1:0]          wr_val,
    input  logic                  buffered,
    input  logic                  step,
    input  logic                  top_step,
    input  logic                  blk,
    input  logic [W-1:0]          cnt,
    input  cmp_timer_pkg::act_e   act,
    input  logic                  dir,
    output logic [W-1:0]          cmp_act,
    output logic                  pin,
    output logic                  ovr
);
    import cmp_timer_pkg::*;

    logic [W-1:0] cmp_buf;
    logic         match;

    // Buffer register: captures every compare write.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_buf <= '0;
        else if (wr_cmp) cmp_buf <= wr_val;
    end

    // Active value: direct write when unbuffered, buffer copy at TOP otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                         cmp_act <= '0;
        else if (!buffered && wr_cmp)       cmp_act <= wr_val;
        else if (buffered && top_step)      cmp_act <= cmp_buf;
    end

    assign match = step && !blk && (cnt == cmp_act);

    // Pin register: applies toggle, clear or set on a match.
    always_ff @(posedge clk) begin
        if (!rst_n) pin <= 1'b0;
        else if (match) begin
            case (act)
                ACT_TOGGLE: pin <= ~pin;
                ACT_CLEAR:  pin <= 1'b0;
                ACT_SET:    pin <= 1'b1;
                default:    pin <= pin;
            endcase
        end
    end

    assign ovr = (act != ACT_OFF) && dir;

    assert_off_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_OFF) |=> (pin == $past(pin)));

    assert_set_action_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !blk && cnt == cmp_act && act == ACT_SET) |=> pin);

    assert_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (blk && step) |=> $stable(pin));

    assert_buffer_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (buffered && !top_step) |=> $stable(cmp_act));

endmodule

// File: rtl/cmp_timer.sv
// Module: top of the dual-channel compare timer.
// Decodes register writes, holds the control byte and instantiates the
// prescaler, the counter and one compare channel per output.
// Assumes a single write per cycle. Control bits 3:2 are always zero.
module cmp_timer #(
    parameter int W   = 16,
    parameter int DIV = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [2:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         cnt_run,
    input  logic         dir_a,
    input  logic         dir_b,
    output logic [W-1:0] count,
    output logic         ovf_flag,
    output logic         pin_a,
    output logic         pin_b,
    output logic         ovr_a,
    output logic         ovr_b
);
    import cmp_timer_pkg::*;

    localparam int NCH = 2;

    logic [7:0]     ctrl_q;
    logic           tick, step, top_step, blk;
    logic           wr_cnt, clr_ovf, buffered;
    wave_e          wave;
    logic [W-1:0]   cmp_act [NCH];
    logic [NCH-1:0] pins, ovrs, dirs;

    assign wr_cnt   = wr_en && (wr_addr == ADDR_CNT);
    assign clr_ovf  = wr_en && (wr_addr == ADDR_FLAG) && wr_data[0];
    assign wave     = wave_e'(ctrl_q[1:0]);
    assign buffered = ctrl_q[1];
    assign dirs     = {dir_b, dir_a};

    // Control byte: writable action and wave fields; bits 3:2 stay zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 ctrl_q <= '0;
        else if (wr_en && wr_addr == ADDR_CTRL)     ctrl_q <= {wr_data[7:4], 2'b00, wr_data[1:0]};
    end

    cmp_prescaler #(.DIV(DIV)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(cnt_run), .tick(tick)
    );

    cmp_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_cnt(wr_cnt),
        .wr_val(wr_data), .clr_ovf(clr_ovf), .wave(wave),
        .ctc_top(cmp_act[0]), .cnt(count), .ovf(ovf_flag), .blk(blk),
        .step(step), .top_step(top_step)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic wr_cmp_i;
        assign wr_cmp_i = wr_en && (wr_addr == ADDR_CMPA + 3'(i));

        cmp_channel #(.W(W)) u_ch (
            .clk(clk), .rst_n(rst_n), .wr_cmp(wr_cmp_i), .wr_val(wr_data),
            .buffered(buffered), .step(step), .top_step(top_step), .blk(blk),
            .cnt(count), .act(act_e'(ctrl_q[7-2*i -: 2])), .dir(dirs[i]),
            .cmp_act(cmp_act[i]), .pin(pins[i]), .ovr(ovrs[i])
        );
    end

    assign pin_a = pins[0];
    assign pin_b = pins[1];
    assign ovr_a = ovrs[0];
    assign ovr_b = ovrs[1];

    assert_ctrl_rsvd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[3:2] == 2'b00);

endmodule

// File: tb/tb_cmp_timer.sv
// Bench: behavioural reference model of the timer, compared at every falling edge.
module tb_cmp_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        cnt_run = 1'b0;
    logic        dir_a = 1'b0;
    logic        dir_b = 1'b0;
    logic [15:0] count;
    logic        ovf_flag, pin_a, pin_b, ovr_a, ovr_b;

    always #2 clk = ~clk;

    cmp_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cnt_run(cnt_run), .dir_a(dir_a), .dir_b(dir_b),
        .count(count), .ovf_flag(ovf_flag), .pin_a(pin_a), .pin_b(pin_b),
        .ovr_a(ovr_a), .ovr_b(ovr_b)
    );

    int checks = 0;
    int fails  = 0;
    bit started = 0;
    bit finished = 0;
    string phase = "R1";

    // Reference model state
    int m_p, m_cnt, m_ovf, m_blk, m_ctrl;
    int m_act [2];
    int m_buf [2];
    int m_pin [2];

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Model update on each rising edge from the inputs held across it.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_p = 0; m_cnt = 0; m_ovf = 0; m_blk = 0; m_ctrl = 0;
            for (int i = 0; i < 2; i++) begin m_act[i] = 0; m_buf[i] = 0; m_pin[i] = 0; end
        end else begin
            int  wave, top, n_cnt, n_ovf, n_blk, n_p, com;
            bit  tick, wrc, stp, attop, buffered, match;
            int  n_act [2];
            int  n_pin [2];
            tick  = cnt_run && (m_p == 7);
            wrc   = wr_en && (wr_addr == 3);
            stp   = tick && !wrc;
            wave  = m_ctrl & 3;
            buffered = (wave >= 2);
            top   = (wave == 1) ? m_act[0] : 65535;
            attop = (m_cnt == top);
            n_p   = !cnt_run ? 0 : (m_p == 7 ? 0 : m_p + 1);
            for (int i = 0; i < 2; i++) begin
                match = stp && !m_blk && (m_cnt == m_act[i]);
                com = (m_ctrl >> (6 - 2*i)) & 3;
                n_pin[i] = m_pin[i];
                if (match) begin
                    if (com == 1) n_pin[i] = 1 - m_pin[i];
                    else if (com == 2) n_pin[i] = 0;
                    else if (com == 3) n_pin[i] = 1;
                end
                n_act[i] = m_act[i];
                if (wr_en && wr_addr == 3'(i + 1) && !buffered) n_act[i] = wr_data;
                else if (buffered && stp && attop) n_act[i] = m_buf[i];
                if (wr_en && wr_addr == 3'(i + 1)) m_buf[i] = wr_data;
            end
            n_ovf = m_ovf;
            if (stp && m_cnt == 65535) n_ovf = 1;
            else if (wr_en && wr_addr == 4 && wr_data[0]) n_ovf = 0;
            n_cnt = wrc ? int'(wr_data) : (stp ? (attop ? 0 : (m_cnt + 1) & 16'hFFFF) : m_cnt);
            n_blk = wrc ? 1 : (tick ? 0 : m_blk);
            if (wr_en && wr_addr == 0) m_ctrl = int'(wr_data[7:0]) & 8'hF3;
            m_p = n_p; m_cnt = n_cnt; m_ovf = n_ovf; m_blk = n_blk;
            for (int i = 0; i < 2; i++) begin m_act[i] = n_act[i]; m_pin[i] = n_pin[i]; end
        end
        started = 1;
    end

    // Compare all outputs with the model on every falling edge.
    always @(negedge clk) begin
        if (started && !finished) begin
            chk(phase, "count", {16'b0, count}, m_cnt);
            chk(phase, "ovf_flag", {31'b0, ovf_flag}, m_ovf);
            chk(phase, "pin_a", {31'b0, pin_a}, m_pin[0]);
            chk(phase, "pin_b", {31'b0, pin_b}, m_pin[1]);
            chk(phase, "ovr_a", {31'b0, ovr_a}, (((m_ctrl >> 6) & 3) != 0) && dir_a);
            chk(phase, "ovr_b", {31'b0, ovr_b}, (((m_ctrl >> 4) & 3) != 0) && dir_b);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "count at reset", {16'b0, count}, 0);
        chk("R1", "pins at reset", {30'b0, pin_b, pin_a}, 0);
        chk("R1", "flags at reset", {29'b0, ovf_flag, ovr_b, ovr_a}, 0);
        #1 rst_n = 1'b1;
        idle(4);

        // R2: stepping every 8 cycles, hold while stopped
        phase = "R2";
        cnt_run = 1'b1; idle(41);
        cnt_run = 1'b0; idle(11);
        cnt_run = 1'b1; idle(20);

        // R7: override needs a nonzero action and a set direction
        phase = "R7";
        wr(0, 16'h0070);
        dir_a = 1'b0; dir_b = 1'b1; idle(2);
        chk("R7", "ovr_a dir low", {31'b0, ovr_a}, 0);
        chk("R7", "ovr_b dir high", {31'b0, ovr_b}, 1);
        dir_a = 1'b1; idle(2);

        // R5: toggle on A, set then clear on B
        phase = "R5";
        wr(0, 16'h0070);
        wr(1, 16'd3); wr(2, 16'd2); wr(3, 16'd0);
        idle(70);
        wr(0, 16'h0060); wr(2, 16'd4); wr(3, 16'd0);
        idle(70);

        // R6: action off holds the pin and drops the override
        phase = "R6";
        wr(0, 16'h0020); wr(3, 16'd0);
        idle(60);

        // R3: wrap sets the overflow flag, write-one clears it
        phase = "R3";
        wr(0, 16'h0000); wr(3, 16'hFFFD);
        idle(40);
        wr(4, 16'h0000); idle(3);
        wr(4, 16'h0001); idle(10);

        // R4: clear-on-match restarts at channel A's value
        phase = "R4";
        wr(0, 16'h0041); wr(1, 16'd4); wr(3, 16'd0);
        idle(90);

        // R8: a counter write blocks the next match
        phase = "R8";
        wr(0, 16'h0040); wr(1, 16'h0020); wr(3, 16'h0020);
        idle(30);
        wr(3, 16'h001E); idle(30);

        // R10: repeated counter writes override stepping
        phase = "R10";
        for (int k = 0; k < 12; k++) wr(3, 16'h0100 + 16'(k));
        wr(0, 16'h00FC); idle(3);

        // R9: buffered mode takes new compare values only at all-ones
        phase = "R9";
        wr(0, 16'h0072); wr(1, 16'hFFF8); wr(3, 16'hFFF0);
        wr(1, 16'h0002); wr(2, 16'h0003);
        idle(200);
        wr(0, 16'h0070); wr(1, 16'h0004); wr(3, 16'd0);
        idle(60);

        finish_run();
    end

endmodule